// File: doc/BRIEF.md
# Single-Wire Bus Slave ROM Command Responder

This block is the addressing front end of a slave on a single-wire, multidrop bus. The line is open drain and idles high. A fast system clock samples it. The block finds bus resets by timing low periods, answers each reset with a presence pulse, and then takes in an 8-bit ROM command. It serves five commands against a 64-bit identity input:

- **Read:** sends the identity to the master.
- **Match:** compares the identity with bits written by the master.
- **Skip:** selects the device without any identity transfer.
- **Search:** binary-tree enumeration of all devices on the bus.
- **Alarm search:** the same enumeration, taken part in only when the alarm input is set.

When addressing succeeds, a `selected_o` level tells a downstream function layer that it owns the bus until the next reset.

All bus timing is set in microseconds and scaled by one parameter, the number of clock cycles per microsecond. The only drive toward the line is `pull_o`, a pull-down enable. The pad ties the line low while it is high and releases the line otherwise. Several responders on one line therefore form a wired-AND. Every port is a plain level or bit. Data moves one bit per bus slot at the pace the master sets, so there is no valid/ready stream and no back-pressure. The master cannot be stalled, and the block must keep up with every slot.

Top module: `onew_rom_responder`

## Requirements
- R1: After `rst_n` is released, `pull_o` is low (line released) and `selected_o` is low.
- R2: A low period of at least RST_US µs is a bus reset. A shorter low period produces no presence pulse.
- R3: After the rising edge that ends a bus reset, the block leaves the line released for PW_US µs and then pulls it low for PL_US µs (presence).
- R4: After presence, the next 8 written bits form the command, least significant bit first. The codes are 33h read, 55h match, CCh skip, F0h search and ECh alarm search.
- R5: On read, the block sends identity bits 0 to 63 in that order. For a 0 bit it pulls the line for SLOT_US µs from the slot's falling edge; for a 1 bit it leaves the line released. After bit 63, `selected_o` goes high.
- R6: On match, the block compares the next 64 written bits with identity bits 0 to 63. If all agree, `selected_o` goes high. On any disagreement it drives nothing until the next reset, and `selected_o` stays low.
- R7: On skip, `selected_o` goes high as soon as the command's last bit has been sampled.
- R8: On search, for each identity bit i the block sends bit i, then sends its complement, then reads the master's choice. If the choice differs from bit i, the block drops out silently until reset. When several responders take part, the line carries the AND of their values. After bit 63, the device that is still in raises `selected_o`.
- R9: Alarm search behaves like search when `alarm_i` is high at command decode. Otherwise the block stays silent until reset.
- R10: A bus reset at any point, including inside a slot where the block is pulling, aborts the command, releases the line, clears `selected_o` and leads to a normal presence pulse.
- R11: An unrecognised command code leaves the block silent, with `selected_o` low, until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Raw sample of the bus line (synchronised inside) |
| pull_o | output | 1 | Pull-down enable: 1 ties the line low, 0 releases it |
| id_i | input | 64 | Identity: family code in bits 7:0, serial number in bits 55:8, check byte in bits 63:56 |
| alarm_i | input | 1 | Alarm condition; gates taking part in alarm search |
| selected_o | output | 1 | Device addressed; cleared by every bus reset |

## Verification
Reset detection can coincide with an active slot in which the block is driving a 0. The bench provokes this by starting a long reset low on the read slot of an identity bit that is 0. The block must release its pull, drop `selected_o` and produce a well-timed presence pulse. A skip then has to select cleanly.

Search is judged with two responders on a modelled wired-AND line. The bench computes the expected bit and complement from both identities and from which devices are still taking part. It also confirms that each pass finds the expected identity and selects only that device.

// File: rtl/onew_pkg.sv
package onew_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] OP_READ   = 8'h33;
  localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
  localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;
  localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;
  localparam logic [CMD_W-1:0] OP_ALARM  = 8'hEC;

  typedef enum logic [1:0] {L_IDLE, L_PWAIT, L_PLOW} link_st_t;

  typedef enum logic [3:0] {
    R_WAIT, R_CMD, R_READ, R_MATCH, R_SBIT, R_SCMP, R_SDIR, R_SEL, R_DROP
  } rom_st_t;
endpackage

// File: rtl/onew_sync.sv
module onew_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic fell,
  output logic rose
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      prev  <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign fell = prev & ~q;
  assign rose = ~prev & q;
endmodule

// File: rtl/onew_link.sv
module onew_link
  import onew_pkg::*;
#(
  parameter int US_CYC  = 100,
  parameter int RST_US  = 480,
  parameter int PW_US   = 30,
  parameter int PL_US   = 120,
  parameter int SLOT_US = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic q,
  input  logic fell,
  input  logic rose,
  input  logic tx_en,
  input  logic tx_bit,
  output logic pull,
  output logic reset_evt,
  output logic pres_done,
  output logic slot_ev,
  output logic slot_bit
);
  localparam int RST_CYC  = RST_US * US_CYC;
  localparam int PW_CYC   = PW_US * US_CYC;
  localparam int PL_CYC   = PL_US * US_CYC;
  localparam int SLOT_CYC = SLOT_US * US_CYC;
  localparam int LW       = $clog2(RST_CYC + 1);

  link_st_t        st;
  logic [LW-1:0]   low_cnt;
  logic [LW-1:0]   tcnt;
  logic            rst_seen;
  logic            slot_act;
  logic            drive0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= L_IDLE;
      low_cnt   <= '0;
      tcnt      <= '0;
      rst_seen  <= 1'b0;
      slot_act  <= 1'b0;
      drive0    <= 1'b0;
      reset_evt <= 1'b0;
      pres_done <= 1'b0;
      slot_ev   <= 1'b0;
      slot_bit  <= 1'b1;
    end else begin
      reset_evt <= 1'b0;
      pres_done <= 1'b0;
      slot_ev   <= 1'b0;
      if (q) low_cnt <= '0;
      else if (low_cnt != LW'(RST_CYC)) low_cnt <= low_cnt + 1'b1;

      if (!q && low_cnt == LW'(RST_CYC - 1)) begin
        reset_evt <= 1'b1;
        rst_seen  <= 1'b1;
        st        <= L_IDLE;
        slot_act  <= 1'b0;
        drive0    <= 1'b0;
      end else begin
        case (st)
          L_IDLE: begin
            if (rose && rst_seen) begin
              st       <= L_PWAIT;
              tcnt     <= '0;
              rst_seen <= 1'b0;
            end else if (slot_act) begin
              if (tcnt == LW'(SLOT_CYC - 1)) begin
                slot_act <= 1'b0;
                drive0   <= 1'b0;
                slot_ev  <= 1'b1;
                slot_bit <= q;
              end else begin
                tcnt <= tcnt + 1'b1;
              end
            end else if (fell && !rst_seen) begin
              slot_act <= 1'b1;
              tcnt     <= '0;
              drive0   <= tx_en & ~tx_bit;
            end
          end
          L_PWAIT: begin
            if (tcnt == LW'(PW_CYC - 1)) begin
              st   <= L_PLOW;
              tcnt <= '0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          L_PLOW: begin
            if (tcnt == LW'(PL_CYC - 1)) begin
              st        <= L_IDLE;
              pres_done <= 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          default: st <= L_IDLE;
        endcase
      end
    end
  end

  assign pull = (st == L_PLOW) | drive0;

  // R3: the wait phase before presence never drives the line
  p_quiet_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == L_PWAIT) |-> !pull);
  // R3: presence starts only on a rising edge of the line
  p_pres_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == L_PWAIT) |-> $past(rose));
  // R10: a detected reset releases the line on the next cycle
  p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_evt |=> !pull);
  // R4: one sample per slot
  p_one_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_ev |=> !slot_ev);
endmodule

// File: rtl/onew_rom.sv
module onew_rom
  import onew_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reset_evt,
  input  logic            pres_done,
  input  logic            slot_ev,
  input  logic            slot_bit,
  input  logic [ID_W-1:0] id,
  input  logic            alarm,
  output logic            tx_en,
  output logic            tx_bit,
  output logic            selected
);
  localparam int IW = $clog2(ID_W);

  rom_st_t          st;
  logic [CMD_W-2:0] cmd_sh;
  logic [CMD_W-1:0] cmd_next;
  logic [IW-1:0]    bcnt;
  logic             idbit;
  logic             last;

  always_comb begin
    idbit    = id[bcnt];
    last     = (bcnt == IW'(ID_W - 1));
    cmd_next = {slot_bit, cmd_sh};
    tx_en    = (st == R_READ) || (st == R_SBIT) || (st == R_SCMP);
    tx_bit   = (st == R_SCMP) ? ~idbit : idbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= R_WAIT;
      cmd_sh   <= '0;
      bcnt     <= '0;
      selected <= 1'b0;
    end else if (reset_evt) begin
      st       <= R_WAIT;
      selected <= 1'b0;
    end else if (pres_done) begin
      st   <= R_CMD;
      bcnt <= '0;
    end else if (slot_ev) begin
      case (st)
        R_CMD: begin
          cmd_sh <= cmd_next[CMD_W-1:1];
          if (bcnt == IW'(CMD_W - 1)) begin
            bcnt <= '0;
            case (cmd_next)
              OP_READ:   st <= R_READ;
              OP_MATCH:  st <= R_MATCH;
              OP_SEARCH: st <= R_SBIT;
              OP_ALARM:  st <= alarm ? R_SBIT : R_DROP;
              OP_SKIP: begin
                st       <= R_SEL;
                selected <= 1'b1;
              end
              default:   st <= R_DROP;
            endcase
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        R_READ: begin
          if (last) begin
            st       <= R_SEL;
            selected <= 1'b1;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        R_SBIT: st <= R_SCMP;
        R_SCMP: st <= R_SDIR;
        R_MATCH, R_SDIR: begin
          if (slot_bit != idbit) begin
            st <= R_DROP;
          end else if (last) begin
            st       <= R_SEL;
            selected <= 1'b1;
          end else begin
            bcnt <= bcnt + 1'b1;
            if (st == R_SDIR) st <= R_SBIT;
          end
        end
        default: ;
      endcase
    end
  end

  // R10: every bus reset drops the selection
  p_sel_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_evt |=> !selected);
  // R6: a dropped responder stays out until reset
  p_drop_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == R_DROP && !reset_evt) |=> (st == R_DROP));
  // R8: bit, complement, choice in strict order
  p_search_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == R_SBIT && slot_ev && !reset_evt && !pres_done) |=> (st == R_SCMP));
  // R5: selection only rises on a sampled slot
  p_sel_on_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> $past(slot_ev));
endmodule

// File: rtl/onew_rom_responder.sv
module onew_rom_responder #(
  parameter int US_CYC      = 100,
  parameter int RST_US      = 480,
  parameter int PW_US       = 30,
  parameter int PL_US       = 120,
  parameter int SLOT_US     = 30,
  parameter int SYNC_STAGES = 2,
  parameter int ID_W        = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_i,
  output logic            pull_o,
  input  logic [ID_W-1:0] id_i,
  input  logic            alarm_i,
  output logic            selected_o
);
  logic q, fell, rose;
  logic tx_en, tx_bit;
  logic reset_evt, pres_done, slot_ev, slot_bit;

  onew_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_i), .q(q), .fell(fell), .rose(rose)
  );

  onew_link #(
    .US_CYC(US_CYC), .RST_US(RST_US), .PW_US(PW_US), .PL_US(PL_US), .SLOT_US(SLOT_US)
  ) u_link (
    .clk(clk), .rst_n(rst_n), .q(q), .fell(fell), .rose(rose),
    .tx_en(tx_en), .tx_bit(tx_bit), .pull(pull_o), .reset_evt(reset_evt),
    .pres_done(pres_done), .slot_ev(slot_ev), .slot_bit(slot_bit)
  );

  onew_rom #(.ID_W(ID_W)) u_rom (
    .clk(clk), .rst_n(rst_n), .reset_evt(reset_evt), .pres_done(pres_done),
    .slot_ev(slot_ev), .slot_bit(slot_bit), .id(id_i), .alarm(alarm_i),
    .tx_en(tx_en), .tx_bit(tx_bit), .selected(selected_o)
  );

  // R1: outputs are known once out of reset
  p_known_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({pull_o, selected_o}));
endmodule

// File: tb/onew_rom_responder_tb.sv
module onew_rom_responder_tb;
  localparam logic [63:0] ID_A = 64'h3C00_00C0_FFEE_0128;
  localparam logic [63:0] ID_B = 64'h3C00_00C0_FFEE_0138;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_pull = 1'b0;
  logic peer_on = 1'b0;
  logic alarm_a = 1'b0;
  logic alarm_b = 1'b0;
  logic pull_a, pull_b, sel_a, sel_b;
  logic line;
  int   nchk = 0;
  int   nfail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  assign line = ~(m_pull | pull_a | (peer_on & pull_b));

  onew_rom_responder #(.US_CYC(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_i(line), .pull_o(pull_a),
    .id_i(ID_A), .alarm_i(alarm_a), .selected_o(sel_a)
  );

  onew_rom_responder #(.US_CYC(1)) u_peer (
    .clk(clk), .rst_n(rst_n), .line_i(line), .pull_o(pull_b),
    .id_i(ID_B), .alarm_i(alarm_b), .selected_o(sel_b)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns 1 when the presence window looks right
  task automatic bus_reset(output bit ok);
    logic a, b, c;
    m_pull = 1'b1; wait_n(500);
    m_pull = 1'b0; wait_n(20); a = line;
    wait_n(60); b = line;
    wait_n(170); c = line;
    ok = (a === 1'b1) && (b === 1'b0) && (c === 1'b1);
  endtask

  task automatic wr_bit(input bit b);
    m_pull = 1'b1; wait_n(b ? 5 : 60);
    m_pull = 1'b0; wait_n(b ? 75 : 20);
  endtask

  task automatic rd_bit(output logic b);
    m_pull = 1'b1; wait_n(2);
    m_pull = 1'b0; wait_n(13); b = line;
    wait_n(60);
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_bit(v[i]);
  endtask

  task automatic rd_n(input int n, output logic [63:0] v);
    logic b;
    v = '1;
    for (int i = 0; i < n; i++) begin rd_bit(b); v[i] = b; end
  endtask

  task automatic search_pass(input logic [7:0] cmd, input bit pref, input bit pa,
                             input bit pb, output logic [63:0] found, output int errs);
    logic b, c, eb, ec, dir;
    bit ok;
    errs = 0; found = '0;
    bus_reset(ok);
    if (!ok) errs++;
    wr_byte(cmd);
    for (int i = 0; i < 64; i++) begin
      rd_bit(b); rd_bit(c);
      eb = (pa ? ID_A[i] : 1'b1) & (pb ? ID_B[i] : 1'b1);
      ec = (pa ? ~ID_A[i] : 1'b1) & (pb ? ~ID_B[i] : 1'b1);
      if (b !== eb || c !== ec) errs++;
      dir = (b != c) ? b : pref;
      if (pa && ID_A[i] != dir) pa = 1'b0;
      if (pb && ID_B[i] != dir) pb = 1'b0;
      found[i] = dir;
      wr_bit(dir);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int errs;
    bit ok;
    wait_n(3);
    chk("R1 pull after reset", 64'(pull_a), 64'd0);
    chk("R1 selected after reset", 64'(sel_a), 64'd0);
    rst_n = 1'b1;
    wait_n(5);
    chk("R1 pull idle", 64'(pull_a), 64'd0);

    // R2: a 400 us low is not a reset
    m_pull = 1'b1; wait_n(400); m_pull = 1'b0; wait_n(80);
    chk("R2 no presence after short low", 64'(line), 64'd1);
    wait_n(200);

    // R3, R4, R5: read
    bus_reset(ok);
    chk("R3 presence window", 64'(ok), 64'd1);
    wr_byte(8'h33);
    rd_n(64, v);
    chk("R5 read identity", v, ID_A);
    chk("R5 selected after read", 64'(sel_a), 64'd1);

    // R7: skip
    bus_reset(ok);
    chk("R10 selected cleared by reset", 64'(sel_a), 64'd0);
    wr_byte(8'hCC);
    wait_n(2);
    chk("R7 selected after skip", 64'(sel_a), 64'd1);

    // R6: match good and bad
    bus_reset(ok);
    wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr_bit(ID_A[i]);
    chk("R6 match selects", 64'(sel_a), 64'd1);
    bus_reset(ok);
    wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr_bit(i == 63 ? ~ID_A[i] : ID_A[i]);
    chk("R6 mismatch not selected", 64'(sel_a), 64'd0);
    rd_n(8, v);
    chk("R6 silent after mismatch", v[7:0], 64'hFF);

    // R11: unknown code
    bus_reset(ok);
    wr_byte(8'hA5);
    rd_n(8, v);
    chk("R11 silent after unknown", v[7:0], 64'hFF);
    chk("R11 not selected", 64'(sel_a), 64'd0);

    // R8: two-device search on a wired-AND line
    peer_on = 1'b1;
    search_pass(8'hF0, 1'b0, 1'b1, 1'b1, v, errs);
    chk("R8 pass0 bit errors", 64'(errs), 64'd0);
    chk("R8 pass0 found", v, ID_A);
    chk("R8 pass0 select", {62'd0, sel_a, sel_b}, 64'd2);
    search_pass(8'hF0, 1'b1, 1'b1, 1'b1, v, errs);
    chk("R8 pass1 bit errors", 64'(errs), 64'd0);
    chk("R8 pass1 found", v, ID_B);
    chk("R8 pass1 select", {62'd0, sel_a, sel_b}, 64'd1);

    // R9: alarm search
    alarm_a = 1'b1; alarm_b = 1'b0;
    search_pass(8'hEC, 1'b1, 1'b1, 1'b0, v, errs);
    chk("R9 alarm bit errors", 64'(errs), 64'd0);
    chk("R9 alarm found", v, ID_A);
    chk("R9 alarm select", {62'd0, sel_a, sel_b}, 64'd2);
    alarm_a = 1'b0;
    bus_reset(ok);
    wr_byte(8'hEC);
    rd_n(2, v);
    chk("R9 no alarm silent", v[1:0], 64'd3);
    chk("R9 no alarm not selected", {62'd0, sel_a, sel_b}, 64'd0);
    peer_on = 1'b0;

    // R10: reset starting on a read slot where the device pulls (bit 4 of ID_A is 0)
    bus_reset(ok);
    wr_byte(8'h33);
    rd_n(4, v);
    chk("R10 partial read", v[3:0], 64'(ID_A[3:0]));
    bus_reset(ok);
    chk("R10 presence after abort", 64'(ok), 64'd1);
    chk("R10 not selected after abort", 64'(sel_a), 64'd0);
    wr_byte(8'hCC);
    wait_n(2);
    chk("R10 skip after abort", 64'(sel_a), 64'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule